// File: doc/BRIEF.md
# Multiply-Divide Unit with Interlock

This block is an iterative 32-bit integer multiply and divide engine that works beside a processor pipeline. It owns two result registers, called HI and LO here. A start command carries two operands and a two-bit operation code. The unit then computes in the background over many clock cycles while the core goes on with unrelated work. A multiply leaves its 64-bit product split across HI (upper half) and LO (lower half). A divide leaves the quotient in LO and the remainder in HI. Neither operation names a destination register.

The core reads HI or LO through a combinational read port. It can also load either register directly with a move-to write. Any such read or write that is requested while the unit is busy raises a stall output in the same cycle. The core holds its request until the stall drops. The stall is an interlock, so the core never needs to poll for completion.

The controller is a three-state machine. In IDLE it waits for a start and accepts move-to writes. In RUN it performs one shift-add step (multiply) or one restoring-division step (divide) per cycle, for 32 cycles. FIX is a single cycle that applies the sign correction and the divide-by-zero override and writes HI and LO. The transitions are as follows. IDLE goes to RUN on start. RUN goes to FIX after its 32nd step. FIX goes to IDLE. A start seen in RUN or FIX returns the machine to RUN with a fresh count.

Top module: `muldiv_unit`

## Requirements
- R1: After reset HI and LO hold zero, busy_o is low and stall_o is low.
- R2: The operation code selects the operation: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide. A multiply leaves product bits 63:32 in HI and bits 31:0 in LO.
- R3: A divide leaves the quotient in LO and the remainder in HI. A signed quotient truncates toward zero, and a signed remainder takes the sign of the dividend.
- R4: A divide by zero completes normally and leaves HI equal to the dividend and LO equal to all ones.
- R5: busy_o rises on the clock edge that samples start_i and stays high for exactly 33 cycles. The result is visible in HI and LO in the first cycle that busy_o is low.
- R6: stall_o is high in a cycle exactly when busy_o is high and at least one of rd_hi_i, rd_lo_i, wr_hi_i or wr_lo_i is high.
- R7: rdata_o shows HI when rd_hi_i is high and LO otherwise, combinationally, in the same cycle.
- R8: While idle, wr_hi_i or wr_lo_i loads wdata_i into HI or LO at the next edge. While busy these writes have no effect and HI and LO hold until the result is written.
- R9: A start issued while busy abandons the current operation. The unit restarts with the new operands, and the 33-cycle count begins again from that start.
- R10: When start_i and a move-to write arrive in the same idle cycle, the start is taken and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a new operation (aborts any running one) |
| op_i | input | 2 | Operation code (see R2) |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| rd_hi_i | input | 1 | Core reads HI |
| rd_lo_i | input | 1 | Core reads LO |
| wr_hi_i | input | 1 | Core writes HI (move-to) |
| wr_lo_i | input | 1 | Core writes LO (move-to) |
| wdata_i | input | 32 | Data for move-to writes |
| rdata_o | output | 32 | Read data, HI or LO |
| stall_o | output | 1 | Interlock: hold the HI/LO access |
| busy_o | output | 1 | Operation in progress |

## Verification
A wrong iteration count or a stuck state first shows as busy_o dropping early or late against the 33-cycle window, and that is caught on the very cycle it happens. A corrupted partial product, a bad restoring step or a bad sign fix stays hidden while busy_o is high. It appears in rdata_o in the first idle cycle after the operation, where the bench compares it on every clock against its own arithmetic. A bad interlock term shows at once on stall_o in the cycle of the access. A write that leaks through while busy shows in HI or LO as soon as the unit goes idle.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIX  = 2'b10
    } md_state_e;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic fix_o,
    output logic busy_o,
    output logic run_o
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    md_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end
            end
            ST_RUN: begin
                if (start_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_FIX;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_FIX: begin
                if (start_i) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        load_o = start_i;
        step_o = 1'b0;
        fix_o  = 1'b0;
        busy_o = 1'b0;
        run_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
            end
            ST_RUN: begin
                busy_o = 1'b1;
                run_o  = 1'b1;
                step_o = !start_i;
            end
            ST_FIX: begin
                busy_o = 1'b1;
                fix_o  = !start_i;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/muldiv_prep.sv
module muldiv_prep #(
    parameter int unsigned W = 32
) (
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] a_mag_o,
    output logic [W-1:0] b_mag_o,
    output logic         is_div_o,
    output logic         neg_res_o,
    output logic         neg_rem_o,
    output logic         div_zero_o
);
    logic signed_op, a_neg, b_neg;

    always_comb begin
        signed_op  = ~op_i[0];
        is_div_o   = op_i[1];
        a_neg      = signed_op & a_i[W-1];
        b_neg      = signed_op & b_i[W-1];
        a_mag_o    = a_neg ? (~a_i + 1'b1) : a_i;
        b_mag_o    = b_neg ? (~b_i + 1'b1) : b_i;
        neg_res_o  = a_neg ^ b_neg;
        neg_rem_o  = a_neg;
        div_zero_o = (b_i == '0);
    end

endmodule

// File: rtl/muldiv_iter.sv
module muldiv_iter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         is_div_i,
    input  logic [W-1:0] a_mag_i,
    input  logic [W-1:0] b_mag_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    logic [W-1:0] hi_r, lo_r, opnd_r;
    logic         div_r;

    // multiply step: conditional add then shift right
    logic [W:0]   msum;
    // divide step: shift left, trial subtract
    logic [W:0]   dsh;
    logic [W-1:0] dsub;
    logic         dge;

    always_comb begin
        msum = {1'b0, hi_r} + (lo_r[0] ? {1'b0, opnd_r} : {(W+1){1'b0}});
        dsh  = {hi_r, lo_r[W-1]};
        dge  = (dsh >= {1'b0, opnd_r});
        dsub = dsh[W-1:0] - opnd_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_r   <= '0;
            lo_r   <= '0;
            opnd_r <= '0;
            div_r  <= 1'b0;
        end else if (load_i) begin
            hi_r   <= '0;
            lo_r   <= is_div_i ? a_mag_i : b_mag_i;
            opnd_r <= is_div_i ? b_mag_i : a_mag_i;
            div_r  <= is_div_i;
        end else if (step_i) begin
            if (div_r) begin
                hi_r <= dge ? dsub : dsh[W-1:0];
                lo_r <= {lo_r[W-2:0], dge};
            end else begin
                hi_r <= msum[W:1];
                lo_r <= {msum[0], lo_r[W-1:1]};
            end
        end
    end

    assign hi_o = hi_r;
    assign lo_o = lo_r;

endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
    parameter int unsigned W = 32
) (
    input  logic         is_div_i,
    input  logic         neg_res_i,
    input  logic         neg_rem_i,
    input  logic         div_zero_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] raw_hi_i,
    input  logic [W-1:0] raw_lo_i,
    output logic [W-1:0] res_hi_o,
    output logic [W-1:0] res_lo_o
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod = {raw_hi_i, raw_lo_i};
        if (!is_div_i) begin
            if (neg_res_i) prod = ~prod + 1'b1;
            res_hi_o = prod[2*W-1:W];
            res_lo_o = prod[W-1:0];
        end else if (div_zero_i) begin
            res_hi_o = dividend_i;
            res_lo_o = '1;
        end else begin
            res_lo_o = neg_res_i ? (~raw_lo_i + 1'b1) : raw_lo_i;
            res_hi_o = neg_rem_i ? (~raw_hi_i + 1'b1) : raw_hi_i;
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic         rd_hi_i,
    input  logic         rd_lo_i,
    input  logic         wr_hi_i,
    input  logic         wr_lo_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] rdata_o,
    output logic         stall_o,
    output logic         busy_o
);
    logic         load, step, fix, run_st;
    logic [W-1:0] a_mag, b_mag, raw_hi, raw_lo, res_hi, res_lo;
    logic         p_div, p_neg, p_nrem, p_dz;

    logic         div_q, neg_q, nrem_q, dz_q;
    logic [W-1:0] dvd_q;
    logic [W-1:0] hi_q, lo_q;

    muldiv_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .load_o(load), .step_o(step), .fix_o(fix),
        .busy_o(busy_o), .run_o(run_st)
    );

    muldiv_prep #(.W(W)) u_prep (
        .op_i(op_i), .a_i(opa_i), .b_i(opb_i),
        .a_mag_o(a_mag), .b_mag_o(b_mag), .is_div_o(p_div),
        .neg_res_o(p_neg), .neg_rem_o(p_nrem), .div_zero_o(p_dz)
    );

    muldiv_iter #(.W(W)) u_iter (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .is_div_i(p_div), .a_mag_i(a_mag), .b_mag_i(b_mag),
        .hi_o(raw_hi), .lo_o(raw_lo)
    );

    muldiv_fix #(.W(W)) u_fix (
        .is_div_i(div_q), .neg_res_i(neg_q), .neg_rem_i(nrem_q),
        .div_zero_i(dz_q), .dividend_i(dvd_q),
        .raw_hi_i(raw_hi), .raw_lo_i(raw_lo),
        .res_hi_o(res_hi), .res_lo_o(res_lo)
    );

    // operation flags captured at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= 1'b0;
            neg_q  <= 1'b0;
            nrem_q <= 1'b0;
            dz_q   <= 1'b0;
            dvd_q  <= '0;
        end else if (load) begin
            div_q  <= p_div;
            neg_q  <= p_neg;
            nrem_q <= p_nrem;
            dz_q   <= p_dz;
            dvd_q  <= opa_i;
        end
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (fix) begin
            hi_q <= res_hi;
            lo_q <= res_lo;
        end else if (!busy_o && !start_i) begin
            if (wr_hi_i) hi_q <= wdata_i;
            if (wr_lo_i) lo_q <= wdata_i;
        end
    end

    assign rdata_o = rd_hi_i ? hi_q : lo_q;
    assign stall_o = busy_o & (rd_hi_i | rd_lo_i | wr_hi_i | wr_lo_i);

endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         rd_hi_i,
    input logic         rd_lo_i,
    input logic         wr_hi_i,
    input logic         wr_lo_i,
    input logic [W-1:0] wdata_i,
    input logic         busy_o,
    input logic         stall_o,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q,
    input logic         run_st
);
    // R6
    stall_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !stall_o);

    // R6
    stall_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (rd_hi_i || rd_lo_i)) |-> stall_o);

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R8
    move_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && wr_hi_i) |=> (hi_q == $past(wdata_i)));

    // R8
    hold_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_st && (wr_hi_i || wr_lo_i)) |=> ($stable(hi_q) && $stable(lo_q)));

    // R10
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && wr_lo_i) |=> $stable(lo_q));

endmodule

bind muldiv_unit muldiv_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rd_hi_i(rd_hi_i), .rd_lo_i(rd_lo_i),
    .wr_hi_i(wr_hi_i), .wr_lo_i(wr_lo_i), .wdata_i(wdata_i),
    .busy_o(busy_o), .stall_o(stall_o),
    .hi_q(hi_q), .lo_q(lo_q), .run_st(run_st)
);

// File: tb/tb_muldiv_unit.sv
`timescale 1ns/1ps
module tb_muldiv_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a = '0, b = '0, wdata = '0;
    logic        rd_hi = 1'b0, rd_lo = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
    logic [31:0] rdata;
    logic        stall, busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    logic [31:0] m_hi = '0, m_lo = '0;
    logic [63:0] m_pend = '0;
    int          m_cnt = 0;

    always #5 clk = ~clk;

    muldiv_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
        .opa_i(a), .opb_i(b), .rd_hi_i(rd_hi), .rd_lo_i(rd_lo),
        .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wdata_i(wdata),
        .rdata_o(rdata), .stall_o(stall), .busy_o(busy)
    );

    function automatic logic [63:0] ref_op(logic [1:0] o, logic [31:0] x, logic [31:0] y);
        longint      sx, sy, sq, sr;
        logic [63:0] ux, uy, r;
        sx = longint'($signed(x));
        sy = longint'($signed(y));
        ux = {32'b0, x};
        uy = {32'b0, y};
        case (o)
            2'b00: r = 64'(sx * sy);
            2'b01: r = ux * uy;
            default: begin
                if (y == 32'b0) r = {x, 32'hffff_ffff};
                else if (o == 2'b10) begin
                    sq = sx / sy;
                    sr = sx % sy;
                    r = {sr[31:0], sq[31:0]};
                end else begin
                    r = {32'(ux % uy), 32'(ux / uy)};
                end
            end
        endcase
        return r;
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // cycle model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = '0; m_lo = '0; m_cnt = 0;
        end else if (start) begin
            m_pend = ref_op(op, a, b);
            m_cnt = 33;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_hi = m_pend[63:32];
                m_lo = m_pend[31:0];
            end
        end else begin
            if (wr_hi) m_hi = wdata;
            if (wr_lo) m_lo = wdata;
        end
    end

    // every-clock comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(busy == (m_cnt > 0), "R5", "busy_o", 64'(busy), 64'(m_cnt > 0));
            chk(stall == ((m_cnt > 0) && (rd_hi || rd_lo || wr_hi || wr_lo)),
                "R6", "stall_o", 64'(stall),
                64'((m_cnt > 0) && (rd_hi || rd_lo || wr_hi || wr_lo)));
            if (m_cnt == 0)
                chk(rdata == (rd_hi ? m_hi : m_lo), "R7", "rdata_o",
                    64'(rdata), 64'(rd_hi ? m_hi : m_lo));
        end
    end

    task automatic start_pulse(logic [1:0] o, logic [31:0] x, logic [31:0] y);
        @(posedge clk); #2;
        start = 1'b1; op = o; a = x; b = y;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic count_busy(output int n);
        bit go;
        n = 0; go = 1'b1;
        while (go) begin
            @(negedge clk);
            if (busy) n++; else go = 1'b0;
        end
    endtask

    task automatic read_check(bit sel_hi, logic [31:0] exp, string tag);
        @(posedge clk); #2;
        rd_hi = sel_hi; rd_lo = !sel_hi;
        @(negedge clk);
        chk(rdata == exp, tag, sel_hi ? "HI" : "LO", 64'(rdata), 64'(exp));
        @(posedge clk); #2;
        rd_hi = 1'b0; rd_lo = 1'b0;
    endtask

    task automatic run_op(logic [1:0] o, logic [31:0] x, logic [31:0] y, string tag);
        int n;
        logic [63:0] e;
        e = ref_op(o, x, y);
        start_pulse(o, x, y);
        count_busy(n);
        chk(n == 33, "R5", "busy length", 64'(n), 64'd33);
        read_check(1'b1, e[63:32], tag);
        read_check(1'b0, e[31:0], tag);
    endtask

    task automatic move_to(bit sel_hi, logic [31:0] d);
        @(posedge clk); #2;
        wr_hi = sel_hi; wr_lo = !sel_hi; wdata = d;
        @(posedge clk); #2;
        wr_hi = 1'b0; wr_lo = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL R5 watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [63:0] e;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'd0);
        chk(stall == 1'b0, "R1", "stall after reset", 64'(stall), 64'd0);
        read_check(1'b1, 32'h0, "R1");
        read_check(1'b0, 32'h0, "R1");

        // R2 multiplies
        run_op(2'b00, 32'hffff_fff9, 32'd6, "R2");
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R2");
        run_op(2'b01, 32'hffff_ffff, 32'hffff_ffff, "R2");
        run_op(2'b01, 32'h1234_5678, 32'h9abc_def0, "R2");
        run_op(2'b00, 32'h7fff_ffff, 32'hffff_ffff, "R2");

        // R3 divides
        run_op(2'b10, 32'hffff_fff9, 32'd2, "R3");
        run_op(2'b10, 32'd7, 32'hffff_fffe, "R3");
        run_op(2'b11, 32'hffff_ffff, 32'd3, "R3");
        run_op(2'b10, 32'h8000_0000, 32'hffff_ffff, "R3");
        run_op(2'b11, 32'd5, 32'd9, "R3");

        // R4 divide by zero
        run_op(2'b10, 32'hffff_fffb, 32'd0, "R4");
        run_op(2'b11, 32'hdead_beef, 32'd0, "R4");

        // R8 move-to while idle
        move_to(1'b1, 32'h1234_abcd);
        move_to(1'b0, 32'h5555_aaaa);
        read_check(1'b1, 32'h1234_abcd, "R8");
        read_check(1'b0, 32'h5555_aaaa, "R8");

        // R6 / R8 access while busy
        e = ref_op(2'b01, 32'd1000, 32'd3000);
        start_pulse(2'b01, 32'd1000, 32'd3000);
        @(posedge clk); #2; wr_hi = 1'b1; wdata = 32'hdead_dead;
        @(negedge clk);
        chk(stall == 1'b1, "R6", "stall on busy write", 64'(stall), 64'd1);
        @(posedge clk); #2; wr_hi = 1'b0; rd_lo = 1'b1;
        @(negedge clk);
        chk(stall == 1'b1, "R6", "stall on busy read", 64'(stall), 64'd1);
        @(posedge clk); #2; rd_lo = 1'b0;
        count_busy(n);
        read_check(1'b1, e[63:32], "R8");

        // R9 abort and restart
        start_pulse(2'b11, 32'hffff_0000, 32'd7);
        repeat (10) @(posedge clk);
        e = ref_op(2'b00, 32'hffff_fffd, 32'd11);
        start_pulse(2'b00, 32'hffff_fffd, 32'd11);
        count_busy(n);
        chk(n == 33, "R9", "busy after restart", 64'(n), 64'd33);
        read_check(1'b1, e[63:32], "R9");
        read_check(1'b0, e[31:0], "R9");

        // R10 start with move-to in same cycle
        e = ref_op(2'b11, 32'd100, 32'd7);
        @(posedge clk); #2;
        start = 1'b1; op = 2'b11; a = 32'd100; b = 32'd7;
        wr_lo = 1'b1; wdata = 32'hbad0_bad0;
        @(posedge clk); #2;
        start = 1'b0; wr_lo = 1'b0;
        count_busy(n);
        read_check(1'b0, e[31:0], "R10");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule